// File: doc/BRIEF.md
# Reloading Interval Timer with Interrupt

The block is a byte-programmed down-counter for periodic or single-delay interrupts. Software loads a reload value into a latch, picks continuous or single-run operation, and starts the counter. While running, the counter steps down once per cycle in which the count enable is high. When it runs out, it reloads from the latch. In continuous mode the reload value appears for two steps in a row, so the count read back never shows zero and one full period takes the latch value plus one steps.

Each run-out sets a sticky interrupt flag. Reading the status register clears it. The interrupt output is the flag gated by an enable mask. A phase-select input places the flag either on the step that performs the reload or one clock later, which covers two silicon variants that count alike but signal one cycle apart. Register reads are returned one clock after the read strobe.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset the latch and counter hold 0xFFFF, the timer is stopped in continuous mode, the flag and mask are clear, and `irq` is low.
- R2: The address map is as follows. A write to 0 sets the latch low byte and a write to 1 sets the latch high byte. A read of 0 or 1 returns the counter low or high byte. Control at address 2 has bit0 run, bit1 single-run and bit4 force-load; bit4 reads as 0. At address 3 a write sets the mask from bit0, and a read returns flag in bit0, mask in bit1 and `irq` in bit7. `rdata` updates the clock after `rd_en`.
- R3: A running counter above 1 decrements by one on each enabled cycle. It does not change when `cnt_en` is low or the timer is stopped.
- R4: In continuous mode, an enabled step at count 1 reloads the latch value, and that value is kept for one further step. With a latch of 5 the readings are 5,4,3,2,1,5,5,4,… and the period is latch+1 steps (17094 gives 17095).
- R5: In single-run mode the run-out reloads the latch and clears the run bit. The counter then holds.
- R6: A write of the latch high byte while stopped also loads the counter with {new high, latch low}. While running, such a write leaves the counter unchanged.
- R7: Writing control with bit4 set copies the latch into the counter on that clock. The run and mode bits are taken from the same write.
- R8: With `early_irq` high the flag is set on the clock of the run-out step. With it low the flag is set one clock later.
- R9: The flag stays set until a status read clears it. A set that coincides with the read wins.
- R10: `irq` is a registered AND of the flag and the mask. It follows mask writes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count step enable |
| early_irq | input | 1 | Interrupt phase select (1 = flag on run-out step) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a run-out, a status read and a mask or control write all landing within a clock or two of each other, with the phase select on either setting. The stimulus gets there with small random latch values and a frequent count enable, so run-outs come every few cycles. Random register traffic then falls on and around them. A cycle model in the bench, built from the requirements, predicts `rdata` and `irq` on every clock. Directed sequences cover the double-reload readout, the 17095-step period and the one-cycle phase difference.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd2;
  localparam logic [ADDR_W-1:0] A_ST  = 2'd3;
  localparam int CTL_RUN   = 0;
  localparam int CTL_SINGLE = 1;
  localparam int CTL_FORCE = 4;
  localparam int ST_FLAG = 0;
  localparam int ST_MASK = 1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              uf_i,
  input  logic              flag_i,
  input  logic              mask_i,
  input  logic              irq_i,
  output logic [CNT_W-1:0]  latch_o,
  output logic              run_o,
  output logic              single_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              rd_clr_o,
  output logic              wr_mask_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [BUS_W-1:0] lat_lo_q, lat_hi_q;
  logic run_q, single_q;
  logic wr_lo, wr_hi, wr_ctl;
  logic [BUS_W-1:0] st_word, ctl_word;

  always_comb begin
    wr_lo     = wr_en && (addr == A_LO);
    wr_hi     = wr_en && (addr == A_HI);
    wr_ctl    = wr_en && (addr == A_CTL);
    wr_mask_o = wr_en && (addr == A_ST);
    rd_clr_o  = rd_en && (addr == A_ST);
    load_o    = (wr_hi && !run_q) || (wr_ctl && wdata[CTL_FORCE]);
    load_val_o = wr_hi ? {wdata, lat_lo_q} : {lat_hi_q, lat_lo_q};
  end

  always_comb begin
    st_word = '0;
    st_word[ST_FLAG] = flag_i;
    st_word[ST_MASK] = mask_i;
    st_word[BUS_W-1] = irq_i;
    ctl_word = '0;
    ctl_word[CTL_RUN] = run_q;
    ctl_word[CTL_SINGLE] = single_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lo_q <= '1;
      lat_hi_q <= '1;
      run_q    <= 1'b0;
      single_q <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (wr_lo) lat_lo_q <= wdata;
      if (wr_hi) lat_hi_q <= wdata;
      if (wr_ctl) begin
        run_q    <= wdata[CTL_RUN];
        single_q <= wdata[CTL_SINGLE];
      end else if (uf_i && single_q) begin
        run_q <= 1'b0;
      end
      if (rd_en) begin
        unique case (addr)
          A_LO:    rdata_o <= cnt_i[BUS_W-1:0];
          A_HI:    rdata_o <= cnt_i[CNT_W-1:BUS_W];
          A_CTL:   rdata_o <= ctl_word;
          default: rdata_o <= st_word;
        endcase
      end
    end
  end

  assign latch_o  = {lat_hi_q, lat_lo_q};
  assign run_o    = run_q;
  assign single_o = single_q;

  assert_single_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (uf_i && single_q && !wr_ctl) |=> !run_q);
  assert_ctl_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (run_q == $past(wdata[CTL_RUN])));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             single_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic hold_q;
  logic step;

  always_comb begin
    step = run_i && tick_i && !load_i;
    uf_o = step && !hold_q && (cnt_q <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      hold_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      hold_q <= 1'b0;
    end else if (step) begin
      if (hold_q) begin
        hold_q <= 1'b0;
      end else if (cnt_q <= CNT_W'(1)) begin
        cnt_q  <= latch_i;
        hold_q <= !single_i;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !hold_q && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!step && !load_i) |=> $stable(cnt_q));
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (uf_o && !single_i) |=> (cnt_q == $past(latch_i)) && hold_q);
  assert_repeat_R4: assert property (@(posedge clk) disable iff (rst)
    (step && hold_q) |=> $stable(cnt_q));
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic early_i,
  input  logic uf_i,
  input  logic rd_clr_i,
  input  logic wr_mask_i,
  input  logic mask_bit_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic pend_q, flag_q, mask_q, irq_q;
  logic set, flag_n, mask_n;

  always_comb begin
    set    = (early_i && uf_i) || pend_q;
    flag_n = set ? 1'b1 : (rd_clr_i ? 1'b0 : flag_q);
    mask_n = wr_mask_i ? mask_bit_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= uf_i && !early_i;
      flag_q <= flag_n;
      mask_q <= mask_n;
      irq_q  <= flag_n && mask_n;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_early_R8: assert property (@(posedge clk) disable iff (rst)
    (early_i && uf_i) |=> flag_q);
  assert_late_R8: assert property (@(posedge clk) disable iff (rst)
    (!early_i && uf_i) |=> ##1 flag_q);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_clr_i) |=> flag_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !pend_q && !uf_i) |=> !flag_q);
  assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !mask_q |-> !irq_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              early_irq,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] latch, cnt, load_val;
  logic run, single, load, uf, rd_clr, wr_mask, flag, mask;

  tmr_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_i(cnt), .uf_i(uf), .flag_i(flag), .mask_i(mask),
    .irq_i(irq), .latch_o(latch), .run_o(run), .single_o(single),
    .load_o(load), .load_val_o(load_val), .rd_clr_o(rd_clr),
    .wr_mask_o(wr_mask), .rdata_o(rdata)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(cnt_en), .run_i(run), .single_i(single),
    .load_i(load), .load_val_i(load_val), .latch_i(latch),
    .cnt_o(cnt), .uf_o(uf)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .early_i(early_irq), .uf_i(uf),
    .rd_clr_i(rd_clr), .wr_mask_i(wr_mask), .mask_bit_i(wdata[ST_MASK - 1]),
    .flag_o(flag), .mask_o(mask), .irq_o(irq)
  );
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, early_irq = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;

  interval_timer dut (.clk(clk), .rst(rst), .cnt_en(cnt_en), .early_irq(early_irq),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // cycle model built from the requirements
  logic [15:0] m_cnt, m_lat;
  logic m_hold, m_run, m_one, m_flag, m_mask, m_pend, m_irq;
  logic [7:0] m_rd;
  always @(posedge clk) begin
    logic wlo, whi, wctl, wst, rst_rd, ld, uf, set, fn, mn;
    if (rst) begin
      m_cnt = 16'hFFFF; m_lat = 16'hFFFF; m_hold = 0; m_run = 0; m_one = 0;
      m_flag = 0; m_mask = 0; m_pend = 0; m_irq = 0; m_rd = 0;
    end else begin
      wlo = wr_en && addr == 0; whi = wr_en && addr == 1;
      wctl = wr_en && addr == 2; wst = wr_en && addr == 3;
      rst_rd = rd_en && addr == 3;
      ld = (whi && !m_run) || (wctl && wdata[4]);
      uf = m_run && cnt_en && !m_hold && m_cnt <= 1 && !ld;
      if (rd_en)
        case (addr)
          2'd0: m_rd = m_cnt[7:0];
          2'd1: m_rd = m_cnt[15:8];
          2'd2: m_rd = {6'd0, m_one, m_run};
          default: m_rd = {m_irq, 5'd0, m_mask, m_flag};
        endcase
      set = (early_irq && uf) || m_pend;
      m_pend = uf && !early_irq;
      fn = set ? 1'b1 : (rst_rd ? 1'b0 : m_flag);
      mn = wst ? wdata[0] : m_mask;
      m_irq = fn && mn; m_flag = fn; m_mask = mn;
      if (ld) begin
        m_cnt = whi ? {wdata, m_lat[7:0]} : m_lat; m_hold = 0;
      end else if (m_run && cnt_en) begin
        if (m_hold) m_hold = 0;
        else if (m_cnt <= 1) begin m_cnt = m_lat; m_hold = !m_one; end
        else m_cnt = m_cnt - 1;
      end
      if (wctl) begin m_run = wdata[0]; m_one = wdata[1]; end
      else if (uf && m_one) m_run = 0;
      if (wlo) m_lat[7:0] = wdata;
      if (whi) m_lat[15:8] = wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] d, input logic t);
    wr_en = w; rd_en = r; addr = a; wdata = d; cnt_en = t;
    @(negedge clk);
    cyc++;
    chk("R2 rdata vs model", rdata, m_rd);
    chk("R10 irq vs model", irq, m_irq);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    step(0, 1, a, 8'd0, 0);
    v = rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    int n, a_cyc;
    logic [7:0] exp_seq [14];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq low", irq, 0);
    rd(0, v); chk("R1 cnt lo", v, 8'hFF);
    rd(1, v); chk("R1 cnt hi", v, 8'hFF);
    rd(2, v); chk("R1 ctl", v, 8'h00);
    rd(3, v); chk("R1 status", v, 8'h00);

    // R4 double reload readout, latch 5
    wr(0, 8'd5); wr(1, 8'd0); wr(2, 8'h01);
    exp_seq = '{5,4,3,2,1,5,5,4,3,2,1,5,5,4};
    for (int i = 0; i < 14; i++) begin
      step(0, 1, 0, 0, 1);
      chk("R4 readout", rdata, exp_seq[i]);
    end

    // R3 no change without enable
    rd(0, v);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    rd(0, n[7:0]);
    chk("R3 hold without cnt_en", n[7:0], v);

    // R5 single run
    wr(2, 8'h00); wr(0, 8'd2); wr(1, 8'd0); wr(2, 8'h03);
    repeat (5) step(0, 0, 0, 0, 1);
    rd(2, v); chk("R5 run cleared", v, 8'h02);
    rd(0, v); chk("R5 counter holds latch", v, 8'd2);

    // R6 high write while running vs stopped
    wr(0, 8'h10); wr(2, 8'h11);
    repeat (3) step(0, 0, 0, 0, 1);
    wr(1, 8'h33);
    rd(1, v); chk("R6 running hi write no load", v, 8'h00);
    wr(2, 8'h00); wr(1, 8'h12);
    rd(1, v); chk("R6 stopped hi load", v, 8'h12);
    rd(0, v); chk("R6 stopped lo from latch", v, 8'h10);

    // R7 force load
    wr(2, 8'h01); repeat (4) step(0, 0, 0, 0, 1);
    wr(2, 8'h11);
    rd(0, v); chk("R7 force lo", v, 8'h10);
    rd(1, v); chk("R7 force hi", v, 8'h12);
    rd(2, v); chk("R7 ctl bit4 reads 0", v, 8'h01);

    // R8 phase: latch 3, measure clocks to irq
    for (int ph = 1; ph >= 0; ph--) begin
      early_irq = ph[0];
      wr(2, 8'h00); wr(0, 8'd3); wr(1, 8'd0); wr(3, 8'h01); rd(3, v);
      wr(2, 8'h01);
      n = 0;
      while (!irq && n < 20) begin step(0, 0, 0, 0, 1); n++; end
      chk(ph ? "R8 early phase" : "R8 late phase", n, ph ? 3 : 4);
    end
    early_irq = 1;

    // R9 sticky, R10 mask gating
    wr(2, 8'h00); rd(3, v);
    wr(3, 8'h00);
    wr(0, 8'd1); wr(1, 8'd0); wr(2, 8'h03);
    step(0, 0, 0, 0, 1);
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R10 masked irq low", irq, 0);
    wr(3, 8'h01);
    chk("R10 irq after mask", irq, 1);
    rd(3, v); chk("R9 flag read", v, 8'h83);
    rd(3, v); chk("R9 flag cleared", v, 8'h02);

    // R4 period with latch 17094
    wr(0, 8'hC6); wr(1, 8'h42); wr(2, 8'h01);
    cnt_en = 1; n = 0;
    while (!irq && n < 20000) begin step(0, 0, 0, 0, 1); n++; end
    a_cyc = cyc;
    step(0, 1, 3, 0, 1);
    n = 0;
    while (!irq && n < 20000) begin step(0, 0, 0, 0, 1); n++; end
    chk("R4 period 17095", cyc - a_cyc, 17095);
    wr(2, 8'h00);

    // random traffic against the model (R2, R3, R8, R9, R10)
    wr(0, 8'd4); wr(1, 8'd0);
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 10;
      if ($urandom % 50 == 0) early_irq = ~early_irq;
      case (op)
        0: step(1, 0, 0, 8'($urandom % 12), ($urandom % 4) != 0);
        1: step(1, 0, 1, ($urandom % 8 == 0) ? 8'($urandom) : 8'd0, ($urandom % 4) != 0);
        2: step(1, 0, 2, {3'd0, 1'($urandom), 2'd0, 1'($urandom), ($urandom % 4) != 0},
                ($urandom % 4) != 0);
        3: step(1, 0, 3, 8'($urandom % 2), ($urandom % 4) != 0);
        4, 5, 6: step(0, 1, 2'($urandom), 0, ($urandom % 4) != 0);
        default: step(0, 0, 0, 0, ($urandom % 4) != 0);
      endcase
    end
    summary();
  end
endmodule